// File: doc/BRIEF.md
# Expansion Interrupt Request Latch

This block keeps track of one interrupt request raised by an expansion device on a shared parallel bus. A one-cycle request pulse from the device sets a pending flag. While the flag is set, the block enables a pull-down onto the system's shared active-low interrupt line. Because only a pull-down is ever driven, several devices can share that line in wired-OR fashion.

The processor finds out which device is interrupting by reading the device-select register. During such a read, the block puts its pending flag onto one data bit, the same bit number that identifies the device when the processor enables it. That bit is driven through a tri-state enable only while the read strobe and the PHI2 data phase are both high. The other seven bits are left undriven at all times.

The processor never has to clear the request explicitly. The write it makes to the select register to activate the device also acknowledges the request. All pins are plain control and data pins: there is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `exp_irq_latch`

## Requirements
- R1: While `rst_n` is low, the pending flag is cleared, `irq_pd_en` is 0, and `bus_oe` and `bus_dout` are all zero.
- R2: If `dev_req` is high at a rising clock edge, `irq_pd_en` is 1 after that edge.
- R3: With `dev_req` and `sel_wr` both low at an edge, the pending flag (seen on `irq_pd_en`) keeps its value across that edge.
- R4: If `sel_wr` is high and `dev_req` is low at an edge, `irq_pd_en` is 0 after that edge.
- R5: If `dev_req` and `sel_wr` are both high at the same edge, the set wins and `irq_pd_en` is 1 after that edge.
- R6: While `sel_rd` and `phi2` are both high, `bus_oe` equals `1 << DEV_BIT` and `bus_dout[DEV_BIT]` equals the pending flag.
- R7: Whenever `sel_rd` or `phi2` is low, `bus_oe` is all zero (every bit high-impedance).
- R8: No bit of `bus_oe` or `bus_dout` other than bit `DEV_BIT` is ever 1. `bus_dout[DEV_BIT]` always carries the pending flag.
- R9: A read (`sel_rd` high, with `sel_wr` and `dev_req` low) leaves the pending flag unchanged.
- R10: `DEV_BIT` may be any value from 0 to 7. The readback bit follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the pending flag updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low system reset |
| dev_req | input | 1 | One-cycle interrupt request pulse from the device |
| sel_rd | input | 1 | Read strobe for the device-select register |
| sel_wr | input | 1 | Write strobe for the device-select register (acknowledges the request) |
| phi2 | input | 1 | Bus data-phase level; readback is driven only while it is high |
| irq_pd_en | output | 1 | Open-drain pull-down enable for the shared active-low interrupt line |
| bus_dout | output | BUS_W | Data value presented to the bus |
| bus_oe | output | BUS_W | Per-bit tri-state enable; 1 means the bit is driven |

## Verification
Two functions of this block can fall on the same edge: the device setting the flag and the processor's select-register write clearing it. The bench provokes the collision for every device bit, starting from both a clear and an already-set flag. It expects the flag to be set after that edge. A plain write with no request must leave the flag clear.

The bench sweeps all 32 combinations of the prior flag state, request, write, read and PHI2, each applied on one edge. For every combination it computes the next flag state, the enable mask and the data bits arithmetically and compares them with the outputs of eight instances, one for each legal `DEV_BIT`.

// File: rtl/exp_irq_pkg.sv
package exp_irq_pkg;

  localparam int unsigned BUS_W_DEF = 8;

  // One-hot mask selecting a single bus bit.
  function automatic logic [BUS_W_DEF-1:0] bit_mask(input int unsigned idx);
    logic [BUS_W_DEF-1:0] m;
    m = '0;
    m[idx[2:0]] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/exp_irq_pend.sv
// Pending-request flag: a request pulse sets it, a select write clears it,
// and the set has priority when both arrive together.
module exp_irq_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);

  logic pend_q;
  logic pend_d;

  always_comb begin
    pend_d = pend_q;
    if (clr_i) pend_d = 1'b0;
    if (set_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/exp_irq_rdqual.sv
// Qualifies the select-register read with the PHI2 data phase.
module exp_irq_rdqual (
  input  logic rst_n,
  input  logic sel_rd_i,
  input  logic phi2_i,
  output logic drive_o
);

  assign drive_o = rst_n & sel_rd_i & phi2_i;

endmodule

// File: rtl/exp_irq_rdbk.sv
// Per-bit tri-state readback: only the device's own bit is ever enabled.
module exp_irq_rdbk #(
  parameter int unsigned BUS_W   = 8,
  parameter int unsigned DEV_BIT = 0
) (
  input  logic             drive_i,
  input  logic             pend_i,
  output logic [BUS_W-1:0] dout_o,
  output logic [BUS_W-1:0] oe_o
);

  for (genvar g = 0; g < BUS_W; g++) begin : g_bit
    if (g == DEV_BIT) begin : g_own
      assign dout_o[g] = pend_i;
      assign oe_o[g]   = drive_i;
    end else begin : g_other
      assign dout_o[g] = 1'b0;
      assign oe_o[g]   = 1'b0;
    end
  end

endmodule

// File: rtl/exp_irq_latch.sv
module exp_irq_latch #(
  parameter int unsigned BUS_W   = exp_irq_pkg::BUS_W_DEF,
  parameter int unsigned DEV_BIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_req,
  input  logic             sel_rd,
  input  logic             sel_wr,
  input  logic             phi2,
  output logic             irq_pd_en,
  output logic [BUS_W-1:0] bus_dout,
  output logic [BUS_W-1:0] bus_oe
);

  localparam int unsigned BIT_W = (BUS_W > 1) ? $clog2(BUS_W) : 1;
  localparam logic [BIT_W-1:0] DEV_IDX = BIT_W'(DEV_BIT);

  initial begin
    if (DEV_BIT >= BUS_W) $error("DEV_BIT out of range");
  end

  logic pend;
  logic rd_drive;

  exp_irq_pend u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (dev_req),
    .clr_i  (sel_wr),
    .pend_o (pend)
  );

  exp_irq_rdqual u_rdqual (
    .rst_n    (rst_n),
    .sel_rd_i (sel_rd),
    .phi2_i   (phi2),
    .drive_o  (rd_drive)
  );

  exp_irq_rdbk #(
    .BUS_W   (BUS_W),
    .DEV_BIT (int'(DEV_IDX))
  ) u_rdbk (
    .drive_i (rd_drive),
    .pend_i  (pend),
    .dout_o  (bus_dout),
    .oe_o    (bus_oe)
  );

  // Open-drain: only a pull-down is ever requested, and only while pending.
  assign irq_pd_en = pend;

endmodule

// File: rtl/exp_irq_latch_chk.sv
module exp_irq_latch_chk #(
  parameter int unsigned BUS_W   = 8,
  parameter int unsigned DEV_BIT = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dev_req,
  input logic             sel_rd,
  input logic             sel_wr,
  input logic             phi2,
  input logic             irq_pd_en,
  input logic [BUS_W-1:0] bus_dout,
  input logic [BUS_W-1:0] bus_oe
);

  logic [BUS_W-1:0] own;
  assign own = BUS_W'(1) << DEV_BIT;

  AST_REQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req |=> irq_pd_en); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_req && !sel_wr) |=> $stable(irq_pd_en)); // R3

  AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && !dev_req) |=> !irq_pd_en); // R4

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && dev_req) |=> irq_pd_en); // R5

  AST_RD_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rd && phi2) |-> (bus_oe == own && bus_dout[DEV_BIT] == irq_pd_en)); // R6

  AST_IDLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_rd && phi2) |-> (bus_oe == '0)); // R7

  AST_OTHER_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_oe & ~own) == '0) && ((bus_dout & ~own) == '0)); // R8

  AST_RD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rd && !sel_wr && !dev_req) |=> $stable(irq_pd_en)); // R9

endmodule

bind exp_irq_latch exp_irq_latch_chk #(
  .BUS_W   (BUS_W),
  .DEV_BIT (DEV_BIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dev_req   (dev_req),
  .sel_rd    (sel_rd),
  .sel_wr    (sel_wr),
  .phi2      (phi2),
  .irq_pd_en (irq_pd_en),
  .bus_dout  (bus_dout),
  .bus_oe    (bus_oe)
);

// File: tb/exp_irq_latch_tb_top.sv
module exp_irq_latch_tb_top;

  localparam int NDEV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dev_req = 1'b0;
  logic sel_rd = 1'b0;
  logic sel_wr = 1'b0;
  logic phi2 = 1'b0;

  logic       irq_v  [NDEV];
  logic [7:0] dout_v [NDEV];
  logic [7:0] oe_v   [NDEV];

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  for (genvar g = 0; g < NDEV; g++) begin : g_dev
    logic       irq_w;
    logic [7:0] dout_w;
    logic [7:0] oe_w;
    exp_irq_latch #(.BUS_W(8), .DEV_BIT(g)) dut_i (
      .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .sel_rd(sel_rd),
      .sel_wr(sel_wr), .phi2(phi2), .irq_pd_en(irq_w),
      .bus_dout(dout_w), .bus_oe(oe_w)
    );
    assign irq_v[g]  = irq_w;
    assign dout_v[g] = dout_w;
    assign oe_v[g]   = oe_w;
  end

  task automatic chk(input string req, input int dev, input logic [7:0] act,
                     input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s dev_bit=%0d actual=%h expected=%h", req, dev, act, exp);
    end
  endtask

  task automatic check_irq(input string req, input logic exp);
    for (int d = 0; d < NDEV; d++) chk(req, d, {7'd0, irq_v[d]}, {7'd0, exp});
  endtask

  task automatic check_bus(input string req, input logic rd, input logic ph,
                           input logic pend);
    for (int d = 0; d < NDEV; d++) begin
      chk(req, d, oe_v[d], (rd && ph) ? (8'd1 << d) : 8'd0);
      chk(req, d, dout_v[d], {7'd0, pend} << d);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; dev_req = 0; sel_rd = 1; sel_wr = 0; phi2 = 1;
    @(negedge clk);
    // R1: reset clears flag and keeps every bit undriven even with a read strobe
    check_irq("R1", 1'b0);
    for (int d = 0; d < NDEV; d++) begin
      chk("R1", d, oe_v[d], 8'd0);
      chk("R1", d, dout_v[d], 8'd0);
    end
    sel_rd = 0; phi2 = 0;
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    // Sweep: prior flag x request x write x read x phi2 (R2..R10 for each DEV_BIT)
    for (int v = 0; v < 32; v++) begin
      logic p0, rq, wr, rd, ph, p1;
      {p0, rq, wr, rd, ph} = v[4:0];
      do_reset();
      if (p0) begin
        @(negedge clk); dev_req = 1;
        @(negedge clk); dev_req = 0;
        check_irq("R2", 1'b1);
      end
      @(negedge clk);
      dev_req = rq; sel_wr = wr; sel_rd = rd; phi2 = ph;
      #1;
      check_bus(rd && ph ? "R6" : "R7", rd, ph, p0);
      check_bus("R8", rd, ph, p0);
      p1 = rq | (p0 & ~wr);
      @(posedge clk); #1;
      if (rq && wr)      check_irq("R5", p1);
      else if (rq)       check_irq("R2", p1);
      else if (wr)       check_irq("R4", p1);
      else if (rd)       check_irq("R9", p1);
      else               check_irq("R3", p1);
      @(negedge clk);
      dev_req = 0; sel_wr = 0; sel_rd = 0; phi2 = 0;
      #1;
      check_bus("R10", 1'b0, 1'b0, p1);
      @(posedge clk); #1;
      check_irq("R3", p1);
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule